// File: doc/BRIEF.md
# Frame Pulse Period Watchdog

This block checks the timing of a nominally 8 kHz frame-reference pulse. A free-running 32.768 MHz sample clock drives it, and that clock has no phase relation to the pulse. The pulse input is asynchronous. It passes through a synchronizer, and each asserting edge marks the start of a new frame. A counter measures the number of sample cycles between consecutive frame marks. The block judges each interval against the nominal 4096-cycle period, with a tolerance of two cycles either way.

An interval that closes too soon is a short frame. The block records it in a sticky early flag. If no mark arrives by the end of the window, the block declares a late frame and records it in a sticky late flag. The counter then restarts so that a dead input keeps being reported. Every violation also produces a one-cycle strobe. Software-style clear inputs reset each flag. The same monitor can sit on a backplane frame signal, a network 8 kHz reference or the sync input of a clock recovery loop.

Top module: `frame_period_monitor`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, early_flag, late_flag and viol_strobe are 0.
- R2: A judged interval of 4094 to 4098 sample cycles, inclusive, sets no flag and produces no strobe.
- R3: A judged interval shorter than 4094 cycles sets early_flag and pulses viol_strobe. If ref_pulse is first sampled high at sample edge k, both outputs change at edge k+2.
- R4: If no frame mark arrives within 4099 cycles of the last reference point, the block sets late_flag and pulses viol_strobe at that edge. A reference point is the last mark or the last late declaration. The count then restarts, so the declaration repeats every 4099 cycles while pulses stay absent. A mark that lands exactly on the 4099th cycle is also reported as late and becomes the new reference.
- R5: After a late declaration that had no coincident mark, the next mark only re-arms the monitor and is not judged.
- R6: The first mark after reset, or after mon_en rises, only arms the monitor and is not judged.
- R7: While mon_en is 0, marks are ignored, no late declaration happens and viol_strobe stays 0. Both flags keep their values.
- R8: Setting clr_early (or clr_late) to 1 for one cycle clears early_flag (or late_flag) at that edge. A violation of the same kind at the same edge wins, and the flag stays 1.
- R9: viol_strobe is never high for two cycles in a row. Whenever it is high, at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitor enable; when low, the monitor is idle and disarmed |
| ref_pulse | input | 1 | Asynchronous 8 kHz frame-reference pulse, active high |
| clr_early | input | 1 | 1 clears early_flag |
| clr_late | input | 1 | 1 clears late_flag |
| early_flag | output | 1 | Sticky: a frame interval was too short |
| late_flag | output | 1 | Sticky: a frame mark was late or missing |
| viol_strobe | output | 1 | One-cycle pulse on each violation |

## Verification
The assertions assume that clear inputs and mon_en are clean, sample-clock-synchronous levels. They also assume that ref_pulse stays high and low for at least one sample cycle each, so the synchronizer produces distinct marks. The stimulus drives every input on the falling clock edge and holds each pulse high for three cycles. It spaces marks at least fifty cycles apart, which keeps every mark a single clean rising edge. Interval lengths are chosen on both sides of each window boundary, including a mark placed exactly on the late boundary.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [1:0] {
        MON_IDLE = 2'd0,
        MON_RUN  = 2'd1,
        MON_SLIP = 2'd2
    } mon_state_e;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_EARLY = 2'd1,
        VERD_LATE  = 2'd2
    } verdict_e;

endpackage

// File: rtl/fpm_edge_sync.sv
module fpm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], async_in};
        nxt_d.last  = cur_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rise_o = cur_q.chain[STAGES-1] & ~cur_q.last;

endmodule

// File: rtl/fpm_period_judge.sv
module fpm_period_judge
    import fpm_pkg::*;
#(
    parameter int NOMINAL_CYCLES = 4096,
    parameter int TOLERANCE      = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     mark,
    output verdict_e verdict_o
);

    localparam int HI_LIMIT = NOMINAL_CYCLES + TOLERANCE;
    localparam int LO_LIMIT = NOMINAL_CYCLES - TOLERANCE;
    localparam int CNT_W    = $clog2(HI_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_COUNT  = CNT_W'(HI_LIMIT);
    localparam logic [CNT_W-1:0] EARLY_BELOW = CNT_W'(LO_LIMIT - 1);

    typedef struct packed {
        mon_state_e       state;
        logic [CNT_W-1:0] count;
    } judge_t;

    judge_t   cur_q, nxt_d;
    verdict_e verdict_d;

    always_comb begin
        nxt_d     = cur_q;
        verdict_d = VERD_NONE;
        if (!enable) begin
            nxt_d.state = MON_IDLE;
            nxt_d.count = '0;
        end else begin
            unique case (cur_q.state)
                MON_IDLE: begin
                    nxt_d.count = '0;
                    if (mark) begin
                        nxt_d.state = MON_RUN;
                    end
                end
                MON_RUN, MON_SLIP: begin
                    if (cur_q.count == LAST_COUNT) begin
                        verdict_d   = VERD_LATE;
                        nxt_d.count = '0;
                        nxt_d.state = mark ? MON_RUN : MON_SLIP;
                    end else if (mark) begin
                        if ((cur_q.state == MON_RUN) && (cur_q.count < EARLY_BELOW)) begin
                            verdict_d = VERD_EARLY;
                        end
                        nxt_d.count = '0;
                        nxt_d.state = MON_RUN;
                    end else begin
                        nxt_d.count = cur_q.count + CNT_W'(1);
                    end
                end
                default: begin
                    nxt_d.state = MON_IDLE;
                    nxt_d.count = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: MON_IDLE, count: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign verdict_o = verdict_d;

endmodule

// File: rtl/fpm_flag_bank.sv
module fpm_flag_bank
    import fpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_e verdict,
    input  logic     clr_early,
    input  logic     clr_late,
    output logic     early_o,
    output logic     late_o,
    output logic     strobe_o
);

    typedef struct packed {
        logic early;
        logic late;
        logic strobe;
    } flags_t;

    flags_t cur_q, nxt_d;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.early  = (cur_q.early & ~clr_early) | (verdict == VERD_EARLY);
        nxt_d.late   = (cur_q.late  & ~clr_late)  | (verdict == VERD_LATE);
        nxt_d.strobe = (verdict != VERD_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign early_o  = cur_q.early;
    assign late_o   = cur_q.late;
    assign strobe_o = cur_q.strobe;

endmodule

// File: rtl/frame_period_monitor.sv
module frame_period_monitor
    import fpm_pkg::*;
#(
    parameter int NOMINAL_CYCLES = 4096,
    parameter int TOLERANCE      = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic ref_pulse,
    input  logic clr_early,
    input  logic clr_late,
    output logic early_flag,
    output logic late_flag,
    output logic viol_strobe
);

    logic     mark;
    verdict_e verdict;

    fpm_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_pulse),
        .rise_o   (mark)
    );

    fpm_period_judge #(
        .NOMINAL_CYCLES (NOMINAL_CYCLES),
        .TOLERANCE      (TOLERANCE)
    ) judge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mon_en),
        .mark      (mark),
        .verdict_o (verdict)
    );

    fpm_flag_bank flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict   (verdict),
        .clr_early (clr_early),
        .clr_late  (clr_late),
        .early_o   (early_flag),
        .late_o    (late_flag),
        .strobe_o  (viol_strobe)
    );

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker (
    input logic clk,
    input logic rst_n,
    input logic mon_en,
    input logic clr_early,
    input logic clr_late,
    input logic early_flag,
    input logic late_flag,
    input logic viol_strobe
);

    a_r3_early_rise_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_flag) |-> viol_strobe);

    a_r4_late_rise_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_flag) |-> viol_strobe);

    a_r7_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !viol_strobe);

    a_r8_early_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (early_flag && !clr_early) |=> early_flag);

    a_r8_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (late_flag && !clr_late) |=> late_flag);

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        viol_strobe |=> !viol_strobe);

    a_r9_strobe_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        viol_strobe |-> (early_flag || late_flag));

endmodule

bind frame_period_monitor fpm_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_en      (mon_en),
    .clr_early   (clr_early),
    .clr_late    (clr_late),
    .early_flag  (early_flag),
    .late_flag   (late_flag),
    .viol_strobe (viol_strobe)
);

// File: tb/frame_period_monitor_tb_top.sv
module frame_period_monitor_tb_top;

    localparam int WIN_LO   = 4094;
    localparam int WIN_LATE = 4099;
    localparam int LATENCY  = 3;

    typedef struct {
        int cyc;
        bit late;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_en = 1'b1;
    logic ref_pulse = 1'b0;
    logic clr_early = 1'b0;
    logic clr_late = 1'b0;
    logic early_flag, late_flag, viol_strobe;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    int   last_raise = 0;
    int   m_state = 0;
    int   m_ref = 0;
    bit   prev_evt = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frame_period_monitor dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mon_en      (mon_en),
        .ref_pulse   (ref_pulse),
        .clr_early   (clr_early),
        .clr_late    (clr_late),
        .early_flag  (early_flag),
        .late_flag   (late_flag),
        .viol_strobe (viol_strobe)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (ref_pulse && cyc >= last_raise + 3) ref_pulse = 1'b0;
        clr_early = 1'b0;
        clr_late  = 1'b0;
    endtask

    // Driver: predicts the verdicts of the next mark, queues them, then raises it
    task automatic send(input int gap);
        int  now;
        bit  consumed;
        now      = last_raise + gap;
        consumed = 1'b0;
        if (mon_en) begin
            if (m_state != 0) begin
                while (!consumed && (now - m_ref >= WIN_LATE)) begin
                    q.push_back('{cyc: m_ref + WIN_LATE + LATENCY, late: 1'b1});
                    if (now - m_ref == WIN_LATE) begin
                        consumed = 1'b1;
                        m_state  = 1;
                        m_ref    = now;
                    end else begin
                        m_ref   = m_ref + WIN_LATE;
                        m_state = 2;
                    end
                end
                if (!consumed) begin
                    if (m_state == 1 && (now - m_ref) < WIN_LO)
                        q.push_back('{cyc: now + LATENCY, late: 1'b0});
                    m_state = 1;
                    m_ref   = now;
                end
            end else begin
                m_state = 1;
                m_ref   = now;
            end
        end
        while (cyc < now) tick();
        ref_pulse  = 1'b1;
        last_raise = cyc;
    endtask

    task automatic clear_and_check(input bit ce, input bit cl, input string tag);
        clr_early = ce;
        clr_late  = cl;
        tick();
        if (ce) check(tag, early_flag, 1'b0);
        if (cl) check(tag, late_flag, 1'b0);
    endtask

    initial begin
        fork
            begin : watchdog
                #(8 * 150000);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got hung run expected completion");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
            begin : monitor
                forever begin
                    @(negedge clk);
                    if (rst_n) begin
                        if (prev_evt) check("R9 strobe one cycle", viol_strobe, 1'b0);
                        prev_evt = viol_strobe;
                        while (q.size() > 0 && q[0].cyc < cyc) begin
                            check(q[0].late ? "R4 missed late strobe" : "R3 missed early strobe",
                                  1'b0, 1'b1);
                            void'(q.pop_front());
                        end
                        if (viol_strobe) begin
                            if (q.size() == 0 || q[0].cyc != cyc) begin
                                check("R2/R5/R6/R7 unexpected strobe", viol_strobe, 1'b0);
                            end else begin
                                if (q[0].late) check("R4 late flag with strobe", late_flag, 1'b1);
                                else           check("R3 early flag with strobe", early_flag, 1'b1);
                                void'(q.pop_front());
                            end
                        end
                    end
                end
            end
        join_none

        repeat (5) @(negedge clk);
        check("R1 early_flag in reset", early_flag, 1'b0);
        check("R1 late_flag in reset", late_flag, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1 strobe after reset", viol_strobe, 1'b0);
        check("R1 late_flag after reset", late_flag, 1'b0);
        last_raise = cyc;

        // R6: arming mark, then R2 window edges
        send(20);
        repeat (6) tick();
        check("R6 first mark not judged", early_flag, 1'b0);
        send(4096);
        send(4094);
        send(4098);
        repeat (6) tick();
        check("R2 no early flag in window", early_flag, 1'b0);
        check("R2 no late flag in window", late_flag, 1'b0);

        // R3: short interval
        send(4093);
        repeat (6) tick();
        check("R3 early flag set", early_flag, 1'b1);
        check("R3 late flag untouched", late_flag, 1'b0);
        clear_and_check(1'b1, 1'b0, "R8 clear early");

        // R4/R5: missing pulse, re-arming mark one cycle after restart
        send(4100);
        send(4096);
        repeat (6) tick();
        check("R4 late flag set", late_flag, 1'b1);
        check("R5 re-arm mark not judged", early_flag, 1'b0);
        clear_and_check(1'b0, 1'b1, "R8 clear late");

        // R4: repeated declarations, then a mark exactly on the late boundary
        send(9000);
        send(4099);
        send(4096);
        repeat (6) tick();
        check("R4 repeated late flag", late_flag, 1'b1);
        check("R5 no early after slip", early_flag, 1'b0);
        clear_and_check(1'b0, 1'b1, "R8 clear late again");

        // R8: early event coincides with clear
        send(4096);
        send(4000);
        tick();
        tick();
        clr_early = 1'b1;
        tick();
        check("R8 event wins over clear", early_flag, 1'b1);

        // R7: disabled monitor ignores marks and absence
        repeat (10) tick();
        mon_en  = 1'b0;
        m_state = 0;
        send(100);
        send(50);
        repeat (5000) tick();
        check("R7 early flag held while disabled", early_flag, 1'b1);
        check("R7 no late declaration while disabled", late_flag, 1'b0);
        clear_and_check(1'b1, 1'b0, "R8 clear early after hold");

        // R6: first mark after enable only arms
        mon_en = 1'b1;
        send(5100);
        repeat (6) tick();
        check("R6 mark after enable not judged", early_flag, 1'b0);
        send(4097);
        send(200);
        repeat (6) tick();
        check("R3 early after re-enable", early_flag, 1'b1);
        check("R2 4097 interval not late", late_flag, 1'b0);

        repeat (20) tick();
        check("R3/R4 all predicted strobes seen", q.size() == 0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule